// File: doc/BRIEF.md
# GPIO Port with Peripheral Direction Override

An eight-pin general-purpose I/O port. Software sets each pin's direction and output value through a direction register and a data register on a small synchronous register bus. Each pin has a tri-state enable and an output value. Both come from one priority mux. When an attached peripheral channel is enabled, it takes the pin from the direction register. When the channel is disabled, the stored direction bit takes back control.

Pin levels pass through a two-stage synchronizer before software or the peripherals can read them. The pins are allotted as follows:

- Pins 0 and 1 are serial channel 0 receive and transmit.
- Pins 2 and 3 are serial channel 1 receive and transmit.
- Pins 4 to 7 belong to a four-wire SPI controller.

The SPI controller supplies its own per-pin direction and value, which it selects by master or slave mode.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register and the data register are 0x00, and every pin_oe_o bit is 0.
- R2: Bus address 2 is the direction register. It can be written and read at any time, with no locking. A bit of 1 makes the pin an output and a bit of 0 makes it an input. Address 3 reads 0x00.
- R3: Bus address 0 writes the data register. On a pin with no active override, pin_oe_o equals the direction bit and pin_o equals the data bit.
- R4: While spi_en_i is 1, pins 4 to 7 take pin_oe_o from spi_dir_i[3:0] and pin_o from spi_out_i[3:0], where bit k maps to pin 4+k. The direction bits and data bits for those pins have no effect.
- R5: While a serial transmit enable is 1, its pin (pin 1 for channel 0, pin 3 for channel 1) has pin_oe_o=1 and pin_o equal to that channel's transmit data input, whatever the direction bit holds.
- R6: While a serial receive enable is 1, its pin (pin 0 for channel 0, pin 2 for channel 1) has pin_oe_o=0 and pin_o=0, whatever the direction bit holds.
- R7: Enabling or disabling an override leaves the stored direction bit unchanged. After the override is disabled, the pin's direction again follows that bit.
- R8: Bus address 1 always reads the synchronized pin levels, and sync_o carries the same levels. A change on pin_i is not visible after one rising clock edge and is visible after two.
- R9: Reading address 0 returns, for each pin, the stored data bit when the pin's effective pin_oe_o is 1, and the synchronized pin level when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, captured on the rising edge |
| bus_addr_i | input | 2 | Register address: 0 data, 1 input, 2 direction |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for bus_addr_i |
| spi_en_i | input | 1 | SPI channel enable |
| spi_dir_i | input | 4 | SPI per-pin output enable for pins 4..7 |
| spi_out_i | input | 4 | SPI per-pin output value for pins 4..7 |
| ser0_rx_en_i | input | 1 | Serial channel 0 receive enable (pin 0) |
| ser0_tx_en_i | input | 1 | Serial channel 0 transmit enable (pin 1) |
| ser0_tx_i | input | 1 | Serial channel 0 transmit data |
| ser1_rx_en_i | input | 1 | Serial channel 1 receive enable (pin 2) |
| ser1_tx_en_i | input | 1 | Serial channel 1 transmit enable (pin 3) |
| ser1_tx_i | input | 1 | Serial channel 1 transmit data |
| pin_i | input | 8 | Pad input levels |
| pin_oe_o | output | 8 | Per-pin tri-state enable, 1 drives |
| pin_o | output | 8 | Per-pin output value |
| sync_o | output | 8 | Synchronized pin levels for the peripherals |

## Verification
The bench builds the block with its default of two synchronizer stages. With that depth it can show that a pin change is absent from the input register after one edge and present after two. With the fixed eight-pin map, one vector table can cover every combination of SPI, transmit and receive overrides against arbitrary direction and data contents. This includes all overrides active at once over an all-zero direction register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SPI_W  = 4;

  localparam int unsigned PIN_S0_RX = 0;
  localparam int unsigned PIN_S0_TX = 1;
  localparam int unsigned PIN_S1_RX = 2;
  localparam int unsigned PIN_S1_TX = 3;
  localparam int unsigned PIN_SPI0  = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_IN   = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] ovr_en_i,
  input  logic [W-1:0] ovr_oe_i,
  input  logic [W-1:0] ovr_val_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] val_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    // peripheral wins, register bits only when no channel owns the pin
    assign oe_o[p]  = ovr_en_i[p] ? ovr_oe_i[p]  : dir_i[p];
    assign val_o[p] = ovr_en_i[p] ? ovr_val_i[p] : data_i[p];
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      eff_oe_i,
  input  logic [W-1:0]      sync_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] dir_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_DIR)  dir_q  <= wdata_i;
      if (addr_i == REG_DATA) data_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      REG_DATA: rdata_o = (data_q & eff_oe_i) | (sync_i & ~eff_oe_i);
      REG_IN:   rdata_o = sync_i;
      REG_DIR:  rdata_o = dir_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == REG_DIR) |=> dir_o == $past(wdata_i));

  assert_dir_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == REG_DIR) |=> $stable(dir_o));
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
  import gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [PORT_W-1:0] bus_wdata_i,
  output logic [PORT_W-1:0] bus_rdata_o,
  input  logic              spi_en_i,
  input  logic [SPI_W-1:0]  spi_dir_i,
  input  logic [SPI_W-1:0]  spi_out_i,
  input  logic              ser0_rx_en_i,
  input  logic              ser0_tx_en_i,
  input  logic              ser0_tx_i,
  input  logic              ser1_rx_en_i,
  input  logic              ser1_tx_en_i,
  input  logic              ser1_tx_i,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] sync_o
);
  logic [PORT_W-1:0] ovr_en, ovr_oe, ovr_val;
  logic [PORT_W-1:0] dir_q, data_q, sync_q;

  always_comb begin
    ovr_en  = '0;
    ovr_oe  = '0;
    ovr_val = '0;
    ovr_en[PIN_S0_RX]  = ser0_rx_en_i;
    ovr_en[PIN_S0_TX]  = ser0_tx_en_i;
    ovr_oe[PIN_S0_TX]  = 1'b1;
    ovr_val[PIN_S0_TX] = ser0_tx_i;
    ovr_en[PIN_S1_RX]  = ser1_rx_en_i;
    ovr_en[PIN_S1_TX]  = ser1_tx_en_i;
    ovr_oe[PIN_S1_TX]  = 1'b1;
    ovr_val[PIN_S1_TX] = ser1_tx_i;
    for (int k = 0; k < SPI_W; k++) begin
      ovr_en[PIN_SPI0+k]  = spi_en_i;
      ovr_oe[PIN_SPI0+k]  = spi_dir_i[k];
      ovr_val[PIN_SPI0+k] = spi_out_i[k];
    end
  end

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_q)
  );

  gpio_pin_mux #(.W(PORT_W)) u_mux (
    .ovr_en_i (ovr_en),
    .ovr_oe_i (ovr_oe),
    .ovr_val_i(ovr_val),
    .dir_i    (dir_q),
    .data_i   (data_q),
    .oe_o     (pin_oe_o),
    .val_o    (pin_o)
  );

  gpio_regs #(.W(PORT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .eff_oe_i(pin_oe_o),
    .sync_i  (sync_q),
    .dir_o   (dir_q),
    .data_o  (data_q),
    .rdata_o (bus_rdata_o)
  );

  assign sync_o = sync_q;

  assert_spi_owns_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_en_i |-> (pin_oe_o[PIN_SPI0 +: SPI_W] == spi_dir_i &&
                  pin_o[PIN_SPI0 +: SPI_W] == spi_out_i));

  assert_tx_drives_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser0_tx_en_i |-> (pin_oe_o[PIN_S0_TX] && pin_o[PIN_S0_TX] == ser0_tx_i));

  assert_rx_floats_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser1_rx_en_i |-> !pin_oe_o[PIN_S1_RX]);

  assert_reg_control_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser0_rx_en_i && !ser0_tx_en_i && !ser1_rx_en_i && !ser1_tx_en_i && !spi_en_i)
      |-> (pin_oe_o == u_regs.dir_o && pin_o == u_regs.data_o));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)              warm_q <= '0;
      else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;

    assert_sync_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3) |-> sync_o == $past(pin_i, 2));
  end
endmodule

// File: tb/gpio_port_ovr_test.sv
module gpio_port_ovr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       spi_en = 1'b0;
  logic [3:0] spi_dir = 4'h0, spi_out = 4'h0;
  logic       s0rx = 1'b0, s0tx = 1'b0, s0d = 1'b0;
  logic       s1rx = 1'b0, s1tx = 1'b0, s1d = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] oe, val, syncv;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  gpio_port_ovr uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .spi_en_i(spi_en), .spi_dir_i(spi_dir), .spi_out_i(spi_out),
    .ser0_rx_en_i(s0rx), .ser0_tx_en_i(s0tx), .ser0_tx_i(s0d),
    .ser1_rx_en_i(s1rx), .ser1_tx_en_i(s1tx), .ser1_tx_i(s1d),
    .pin_i(pin_in), .pin_oe_o(oe), .pin_o(val), .sync_o(syncv)
  );

  typedef struct packed {
    logic [6:0] ctl;  // spi_en, s0rx, s0tx, s0d, s1rx, s1tx, s1d
    logic [3:0] sdir;
    logic [3:0] sout;
    logic [7:0] dir;
    logic [7:0] data;
    logic [7:0] exp_oe;
    logic [7:0] exp_val;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{7'b0000000, 4'h0, 4'h0, 8'hFF, 8'hA5, 8'hFF, 8'hA5},  // R3
    '{7'b0000000, 4'h0, 4'h0, 8'h0F, 8'h3C, 8'h0F, 8'h3C},  // R3
    '{7'b1000000, 4'hA, 4'h6, 8'hFF, 8'h00, 8'hAF, 8'h60},  // R4
    '{7'b0111000, 4'h0, 4'h0, 8'h00, 8'h00, 8'h02, 8'h02},  // R5 R6
    '{7'b0100000, 4'h0, 4'h0, 8'hFF, 8'hFF, 8'hFE, 8'hFE},  // R6
    '{7'b0000110, 4'h0, 4'h0, 8'hFF, 8'hFF, 8'hFB, 8'hF3},  // R5 R6
    '{7'b1111111, 4'h5, 4'hF, 8'h00, 8'h00, 8'h5A, 8'hFA},  // R4 R5 R6
    '{7'b0000000, 4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00}   // R7
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_ctl(input logic [6:0] c, input logic [3:0] sd, input logic [3:0] so);
    {spi_en, s0rx, s0tx, s0d, s1rx, s1tx, s1d} = c;
    spi_dir = sd;
    spi_out = so;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd2, r); check("R1 dir", r, 8'h00);
    bus_read(2'd0, r); check("R1 data", r, 8'h00);
    check("R1 oe", oe, 8'h00);

    // R2 unmapped address
    bus_read(2'd3, r); check("R2 addr3", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      set_ctl(7'b0, 4'h0, 4'h0);
      bus_write(2'd2, VECS[i].dir);
      bus_write(2'd0, VECS[i].data);
      bus_read(2'd2, r); check("R2 dir readback", r, VECS[i].dir);
      set_ctl(VECS[i].ctl, VECS[i].sdir, VECS[i].sout);
      #1;
      check($sformatf("R3-R6 vec%0d oe", i), oe, VECS[i].exp_oe);
      check($sformatf("R3-R6 vec%0d val", i), val, VECS[i].exp_val);
    end

    // R7: override on/off leaves dir bits intact
    set_ctl(7'b0, 4'h0, 4'h0);
    bus_write(2'd2, 8'hFF);
    set_ctl(7'b1100000, 4'h0, 4'h0);
    @(negedge clk);
    check("R7 oe overridden", oe, 8'h0E);
    bus_read(2'd2, r); check("R7 dir kept", r, 8'hFF);
    set_ctl(7'b0, 4'h0, 4'h0);
    #1 check("R7 oe restored", oe, 8'hFF);

    // R8 synchronizer latency
    bus_write(2'd2, 8'h00);
    @(negedge clk);
    pin_in = 8'h5A;
    addr = 2'd1;
    @(negedge clk);
    check("R8 after one edge", rdata, 8'h00);
    @(negedge clk);
    check("R8 after two edges", rdata, 8'h5A);
    check("R8 sync_o", syncv, 8'h5A);

    // R9 data read mixes stored bits and pin levels
    pin_in = 8'hCC;
    bus_write(2'd2, 8'h0F);
    bus_write(2'd0, 8'h33);
    repeat (2) @(negedge clk);
    bus_read(2'd0, r); check("R9 mixed", r, 8'hC3);
    set_ctl(7'b1000000, 4'hF, 4'h0);
    bus_read(2'd0, r); check("R9 spi output pins", r, 8'h33);
    set_ctl(7'b0010000, 4'h0, 4'h0);
    bus_read(2'd0, r); check("R9 tx pin", r, 8'hC3);
    set_ctl(7'b0, 4'h0, 4'h0);
    bus_read(2'd1, r); check("R8 input reg", r, 8'hCC);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule